// File: doc/BRIEF.md
# External Trigger Conditioner

This block sits between an asynchronous external trigger pin and a timer core. It first brings the pin into the timer clock domain. It then applies an optional inversion, so that either rising or falling pin transitions count as active. Finally it divides the frequency of the active transitions by 1, 2, 4 or 8. The divided signal leaves the block as the prescaled trigger. A digital filter outside this block cleans that signal and returns it as the filtered trigger.

The filtered trigger is used in two places. When the edge-clock mode is on, each rising edge of the filtered trigger becomes a one-cycle count-enable pulse for the counter. No derived clock is ever created. A two-way selector also routes either a dedicated clear input or the filtered trigger to the output-reference clear.

All edge detection is synchronous to `clk`. The prescaler counts active edges. Its toggle output completes one full period for every 2^code active input edges.

Top module: `ext_trig_cond`

## Requirements
- R1: With `pol_inv` = 0, a low-to-high transition of `trig_pin` is the active edge. With `pol_inv` = 1, the pin is inverted before any other stage, so a high-to-low pin transition is the active edge.
- R2: With `psc_code` = 0, `trig_psc` follows the polarity-adjusted pin level. The delay is SYNC_STAGES + 1 clock cycles.
- R3: With `psc_code` = k (k = 1..3), `trig_psc` inverts once on every 2^(k-1)-th active edge. One output period therefore spans 2^k active edges, which is a frequency division by 2, 4 or 8. Without an active edge, the output does not change.
- R4: In any cycle where `psc_code` differs from its value in the previous cycle, the edge count returns to zero. An active edge seen in that same cycle is not counted. `trig_psc` keeps its level across the change.
- R5: With `ecm2_en` = 1, each rising edge of `trig_filt` produces exactly one `cnt_en` pulse, one cycle wide. The pulse appears in the cycle after the first high sample of `trig_filt`.
- R6: In the cycle after `ecm2_en` is sampled low, `cnt_en` is low, whatever `trig_filt` does.
- R7: `clr_out` equals `clr_in` when `clr_sel` = 0 and equals `trig_filt` when `clr_sel` = 1. There is no delay.
- R8: While `rst_n` is low, `trig_psc` and `cnt_en` are 0 and the edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset, applied asynchronously |
| trig_pin | input | 1 | Raw external trigger pin (asynchronous) |
| pol_inv | input | 1 | 1 inverts the pin (falling edge active) |
| psc_code | input | PSC_CODE_W | Division code: 0 off, k divides by 2^k |
| ecm2_en | input | 1 | Enables edge-to-count-enable conversion |
| trig_filt | input | 1 | Filtered trigger returned from the external filter |
| clr_sel | input | 1 | Clear source select: 0 dedicated input, 1 filtered trigger |
| clr_in | input | 1 | Dedicated output-reference clear input |
| trig_psc | output | 1 | Prescaled trigger toward the filter |
| cnt_en | output | 1 | One-cycle counter enable per filtered edge |
| clr_out | output | 1 | Selected output-reference clear |

## Verification
The prescaler assertions assume that `trig_filt` and `psc_code` are already synchronous to `clk`. Only `trig_pin` may change at arbitrary times, and it reaches the edge logic only through the synchroniser. The stimulus follows this rule by changing every input half a period away from the sampling edge. The pin is driven as a square wave with random half periods of one to six cycles, so an input edge sometimes lands in the very cycle where the code changes. The filtered trigger is driven with random values, because the count-enable assertions hold for any synchronous input pattern.

// File: rtl/etc_pkg.sv
package etc_pkg;

   // Number of active edges between two inversions of the divided output.
   function automatic int unsigned edges_per_flip(input int unsigned code);
      return (code == 0) ? 1 : (32'd1 << (code - 1));
   endfunction

   // Width of an edge counter that can hold edges_per_flip(max_code) - 1.
   function automatic int unsigned cnt_width(input int unsigned max_code);
      return (max_code > 1) ? (max_code - 1) : 1;
   endfunction

endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("etc_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= d_i;
         end
         assign q_o = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/etc_prescaler.sv
module etc_prescaler
   import etc_pkg::*;
#(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              psc_o
);

   localparam int MAX_CODE = (1 << CODE_W) - 1;
   localparam int CNT_W    = cnt_width(MAX_CODE);

   logic              lvl_d;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  lim;
   logic              out_q;
   logic              act_edge;
   logic              code_moved;

   assign act_edge   = lvl_i & ~lvl_d;
   assign code_moved = (code_i != code_q);

   always_comb begin
      lim = '0;
      if (code_i != '0)
         lim = CNT_W'(edges_per_flip(int'(code_i)) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b0;
         code_q <= '0;
         cnt_q  <= '0;
         out_q  <= 1'b0;
      end else begin
         lvl_d  <= lvl_i;
         code_q <= code_i;
         if (code_i == '0) begin
            cnt_q <= '0;
            out_q <= lvl_i;
         end else if (code_moved) begin
            cnt_q <= '0;
         end else if (act_edge) begin
            if (cnt_q == lim) begin
               cnt_q <= '0;
               out_q <= ~out_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign psc_o = out_q;

   p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == '0) |=> (out_q == $past(lvl_i)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i != '0 && !act_edge) |=> $stable(out_q));

   p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i != '0 && !code_moved && act_edge && cnt_q == lim) |=> (out_q != $past(out_q)));

   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!code_moved) |-> (cnt_q <= lim));

   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      code_moved |=> (cnt_q == '0));

   p_keep_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_moved && code_i != '0) |=> $stable(out_q));

endmodule

// File: rtl/etc_edge_clk.sv
module etc_edge_clk (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic filt_i,
   output logic pulse_o
);

   logic filt_d;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_d  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         filt_d  <= filt_i;
         pulse_q <= en_i & filt_i & ~filt_d;
      end
   end

   assign pulse_o = pulse_q;

   p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   p_from_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(filt_i));

   p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pulse_q);

endmodule

// File: rtl/etc_clr_mux.sv
module etc_clr_mux (
   input  logic sel_i,
   input  logic ded_i,
   input  logic filt_i,
   output logic clr_o
);

   always_comb begin
      unique case (sel_i)
         1'b0:    clr_o = ded_i;
         default: clr_o = filt_i;
      endcase
   end

endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond #(
   parameter int PSC_CODE_W  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trig_pin,
   input  logic                  pol_inv,
   input  logic [PSC_CODE_W-1:0] psc_code,
   input  logic                  ecm2_en,
   input  logic                  trig_filt,
   input  logic                  clr_sel,
   input  logic                  clr_in,
   output logic                  trig_psc,
   output logic                  cnt_en,
   output logic                  clr_out
);

   generate
      if (PSC_CODE_W < 1 || PSC_CODE_W > 3) begin : g_bad_code
         $error("ext_trig_cond: PSC_CODE_W must be 1..3");
      end
   endgenerate

   logic pin_pol;
   logic pin_sync;

   assign pin_pol = trig_pin ^ pol_inv;

   etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_pol),
      .q_o   (pin_sync)
   );

   etc_prescaler #(.CODE_W(PSC_CODE_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pin_sync),
      .code_i (psc_code),
      .psc_o  (trig_psc)
   );

   etc_edge_clk u_eclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (ecm2_en),
      .filt_i  (trig_filt),
      .pulse_o (cnt_en)
   );

   etc_clr_mux u_clr (
      .sel_i  (clr_sel),
      .ded_i  (clr_in),
      .filt_i (trig_filt),
      .clr_o  (clr_out)
   );

   p_clr_ded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_sel |-> (clr_out == clr_in));

   p_clr_filt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sel |-> (clr_out == trig_filt));

   p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!trig_psc && !cnt_en));

endmodule

// File: tb/ext_trig_cond_bench.sv
module ext_trig_cond_bench;

   localparam int CW = 2;
   localparam int S  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_pin = 1'b0;
   logic          pol_inv = 1'b0;
   logic [CW-1:0] psc_code = '0;
   logic          ecm2_en = 1'b0;
   logic          trig_filt = 1'b0;
   logic          clr_sel = 1'b0;
   logic          clr_in = 1'b0;
   logic          trig_psc;
   logic          cnt_en;
   logic          clr_out;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   ext_trig_cond #(.PSC_CODE_W(CW), .SYNC_STAGES(S)) u_ext_trig_cond (
      .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .pol_inv(pol_inv),
      .psc_code(psc_code), .ecm2_en(ecm2_en), .trig_filt(trig_filt),
      .clr_sel(clr_sel), .clr_in(clr_in), .trig_psc(trig_psc),
      .cnt_en(cnt_en), .clr_out(clr_out)
   );

   // Reference model: a delay line of polarised pin samples plus an edge tally.
   bit hist [0:S];
   int edges_seen;
   int prev_code;
   bit prev_filt;
   bit exp_psc;
   bit exp_cnt;
   bit after_change;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= S; i++) hist[i] = 1'b0;
         edges_seen = 0; prev_code = 0; prev_filt = 1'b0;
         exp_psc = 1'b0; exp_cnt = 1'b0; after_change = 1'b0;
      end else begin
         bit seen_edge;
         seen_edge = hist[S-1] && !hist[S];
         if (psc_code == 0) begin
            exp_psc = hist[S-1];
            edges_seen = 0;
         end else if (int'(psc_code) != prev_code) begin
            edges_seen = 0;
            after_change = 1'b1;
         end else if (seen_edge) begin
            edges_seen++;
            if (edges_seen == (1 << (int'(psc_code) - 1))) begin
               exp_psc = !exp_psc;
               edges_seen = 0;
               after_change = 1'b0;
            end
         end
         prev_code = int'(psc_code);
         for (int i = S; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = trig_pin ^ pol_inv;
         exp_cnt = ecm2_en && trig_filt && !prev_filt;
         prev_filt = trig_filt;
      end
   end

   task automatic compare();
      string tag;
      vectors++;
      if (!rst_n) begin
         if (trig_psc !== 1'b0 || cnt_en !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset: trig_psc=%b cnt_en=%b expected 0 0", trig_psc, cnt_en);
         end
         return;
      end
      if (after_change)       tag = "R4";
      else if (psc_code != 0) tag = "R3";
      else if (pol_inv)       tag = "R1";
      else                    tag = "R2";
      if (trig_psc !== exp_psc) begin
         errors++;
         $display("FAIL %s trig_psc=%b expected %b (code %0d)", tag, trig_psc, exp_psc, psc_code);
      end
      if (cnt_en !== exp_cnt) begin
         errors++;
         $display("FAIL %s cnt_en=%b expected %b", exp_cnt ? "R5" : "R6", cnt_en, exp_cnt);
      end
      if (clr_out !== (clr_sel ? trig_filt : clr_in)) begin
         errors++;
         $display("FAIL R7 clr_out=%b expected %b", clr_out, clr_sel ? trig_filt : clr_in);
      end
   endtask

   int half_cnt = 1;

   // Each step compares at the falling edge, then moves the inputs for the next rising edge.
   task automatic step(input int n, input int hp_max, input bit rnd_filt, input bit rnd_code);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         compare();
         half_cnt--;
         if (half_cnt <= 0) begin
            trig_pin = !trig_pin;
            half_cnt = 1 + int'($urandom % hp_max);
         end
         if (rnd_filt) trig_filt = $urandom % 2;
         clr_in = $urandom % 2;
         if (rnd_code && ($urandom % 7 == 0)) psc_code = CW'($urandom);
      end
   endtask

   initial begin
      // R8: outputs held low during reset
      repeat (3) begin @(negedge clk); compare(); end
      @(negedge clk); rst_n = 1'b1;
      // R2: pass-through, rising edge active
      step(60, 4, 1'b0, 1'b0);
      // R1: inverted pin, falling edge active, in both pass and divide modes
      pol_inv = 1'b1; step(60, 4, 1'b0, 1'b0);
      psc_code = 2'd2; step(120, 3, 1'b0, 1'b0);
      pol_inv = 1'b0;
      // R3: each division ratio
      for (int c = 1; c < 4; c++) begin
         psc_code = CW'(c);
         step(200, 6, 1'b0, 1'b0);
      end
      // R4: code changes with fast pin activity so edges land on the change cycle
      step(600, 2, 1'b0, 1'b1);
      psc_code = 2'd3; step(10, 1, 1'b0, 1'b0);
      psc_code = 2'd1; step(10, 1, 1'b0, 1'b0);
      // R5 and R7: edge clock on, filtered trigger random, both clear sources
      ecm2_en = 1'b1; clr_sel = 1'b0; step(200, 3, 1'b1, 1'b1);
      clr_sel = 1'b1; step(200, 3, 1'b1, 1'b1);
      // R6: edge clock off while the filtered trigger keeps toggling
      ecm2_en = 1'b0; step(200, 3, 1'b1, 1'b0);
      ecm2_en = 1'b1; step(50, 3, 1'b1, 1'b0);
      // R8: reset again mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (3) begin @(negedge clk); compare(); end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule